// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit integer core built as five overlapped stages: fetch, decode, execute, memory and write-back. Each stage hands its work to the next through an explicit register bank, so up to five instructions are in flight at once. It executes a small load/store subset: five register-register ALU operations, an add-immediate, word load, word store and a branch taken when a register is zero. Instruction and data storage are two separate word arrays, so a fetch and a data access never compete for a port.

The core has no hazard detection and no forwarding. Programs must place two independent instructions (or NOPs) between a producer and its first consumer. The register file writes in the first half of the cycle and reads in the second half, which makes a distance of three slots enough. Branches are resolved late. The target and the zero test are formed in execute, and the PC is redirected from the memory stage. At that edge the three younger instructions are turned into bubbles.

A test harness fills both arrays through a word-wide load port while reset is held. It then watches a debug port that reports the PC and one strobe per retired register write.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is cleared to 0 and every inter-stage register becomes a bubble. `dbg_pc` reads 0 and `dbg_wr_en` stays low.
- R2: Without a taken branch, the PC advances by 4 on every clock. `dbg_pc` reads 4 one clock after reset is released and 8 after the second clock.
- R3: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0] and immediate [15:0]. The immediate is sign-extended to 32 bits, so ADDI with 0xFFFD adds -3.
- R4: Opcode 0x00 with shamt 0 is a register-register operation that writes rd. Funct 0x20 is ADD, 0x22 is SUB (rs minus rt), 0x24 is AND, 0x25 is OR, and 0x2A is SLT (signed, result 1 or 0).
- R5: ADDI (opcode 0x08) writes rs+imm to rt. LW (opcode 0x23) writes to rt the data word at byte address rs+imm, which uses word index address[9:2].
- R6: SW (opcode 0x2B) writes rt to the data word at byte address rs+imm and raises no register-write strobe. A later LW from the same address returns that value.
- R7: BEQZ (opcode 0x04) is taken when rs is zero. Its target is (branch address + 4) + (imm << 2). When rs is non-zero, execution falls through to the next word.
- R8: A taken branch squashes the three instructions fetched after it. None of them writes a register or memory.
- R9: A value written back in a cycle is visible to an instruction that reads it in decode in that same cycle. A consumer three slots after its producer therefore reads the new value.
- R10: Register 0 always reads 0. A write to it is discarded and raises no strobe.
- R11: Any other opcode, or an R-type word with another funct or a non-zero shamt, acts as a NOP: no register write, no memory write.
- R12: With `ld_en` high, `ld_data` is written at the next clock into word `ld_addr` of the data array when `ld_dmem` is 1, and of the instruction array when it is 0.
- R13: Each retired register write gives exactly one cycle of `dbg_wr_en` with its register and value, in program order, one clock after write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 selects the data array, 0 the instruction array |
| ld_addr | input | 8 | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| dbg_pc | output | 32 | Current fetch PC |
| dbg_wr_en | output | 1 | Register-write strobe, one per retired write |
| dbg_wr_reg | output | 5 | Destination register of the reported write |
| dbg_wr_data | output | 32 | Value of the reported write |

## Verification
One program is run twice, with a different value preloaded in the data array each time. The second run shows that a loaded word reaches the register file through the load path and not from state left over in the pipeline. Positive and negative operands tell SLT's signed compare apart from an unsigned one and show AND/OR on mixed bit patterns. A producer placed exactly three slots before its consumer separates write-first register behaviour from read-first behaviour. A taken branch followed by instructions that would write registers, a not-taken branch on a non-zero register, an unsupported opcode and a write to register 0 each reveal themselves as an extra, missing or misordered write-back in the expected sequence. A final branch-to-self loop checks that the PC stays inside the loop's fetch window.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int INSN_W = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQZ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_t;

  typedef struct packed {
    logic              reg_wr;
    logic              mem_rd;
    logic              mem_wr;
    logic              branch;
    logic              use_imm;
    alu_fn_t           fn;
    logic [RIDX_W-1:0] dest;
  } ctrl_t;

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [XLEN-1:0]          wd,
  input  logic [$clog2(NREGS)-1:0] ra1,
  input  logic [$clog2(NREGS)-1:0] ra2,
  output logic [XLEN-1:0]          rd1,
  output logic [XLEN-1:0]          rd2
);
  localparam int AW = $clog2(NREGS);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  // write-first: a write in this cycle is seen by reads in this cycle
  function automatic logic [XLEN-1:0] rd_port(input logic [AW-1:0] ra,
                                              input logic [XLEN-1:0] stored,
                                              input logic wen,
                                              input logic [AW-1:0] waddr,
                                              input logic [XLEN-1:0] wdata);
    if (ra == '0)                  return '0;
    else if (wen && waddr == ra)   return wdata;
    else                           return stored;
  endfunction

  assign rd1 = rd_port(ra1, regs[ra1], we, wa, wd);
  assign rd2 = rd_port(ra2, regs[ra2], we, wa, wd);

endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:0] ir,
  input  logic              valid,
  output ctrl_t             ctrl,
  output logic [XLEN-1:0]   imm,
  output logic [RIDX_W-1:0] rs,
  output logic [RIDX_W-1:0] rt
);
  logic [5:0]        opc;
  logic [5:0]        fnc;
  logic [4:0]        shamt;
  logic [RIDX_W-1:0] rd;

  assign opc   = ir[31:26];
  assign rs    = ir[25:21];
  assign rt    = ir[20:16];
  assign rd    = ir[15:11];
  assign shamt = ir[10:6];
  assign fnc   = ir[5:0];
  assign imm   = {{(XLEN-16){ir[15]}}, ir[15:0]};

  always_comb begin
    ctrl = '0;
    if (valid) begin
      case (opc)
        OPC_RTYPE: begin
          ctrl.dest = rd;
          if (shamt == '0) begin
            case (fnc)
              FN_ADD:  begin ctrl.fn = ALU_ADD; ctrl.reg_wr = (rd != '0); end
              FN_SUB:  begin ctrl.fn = ALU_SUB; ctrl.reg_wr = (rd != '0); end
              FN_AND:  begin ctrl.fn = ALU_AND; ctrl.reg_wr = (rd != '0); end
              FN_OR:   begin ctrl.fn = ALU_OR;  ctrl.reg_wr = (rd != '0); end
              FN_SLT:  begin ctrl.fn = ALU_SLT; ctrl.reg_wr = (rd != '0); end
              default: ctrl.reg_wr = 1'b0;
            endcase
          end
        end
        OPC_ADDI: begin
          ctrl.dest    = rt;
          ctrl.use_imm = 1'b1;
          ctrl.reg_wr  = (rt != '0);
        end
        OPC_LW: begin
          ctrl.dest    = rt;
          ctrl.use_imm = 1'b1;
          ctrl.mem_rd  = 1'b1;
          ctrl.reg_wr  = (rt != '0);
        end
        OPC_SW: begin
          ctrl.use_imm = 1'b1;
          ctrl.mem_wr  = 1'b1;
        end
        OPC_BEQZ: begin
          ctrl.branch = 1'b1;
        end
        default: ctrl = '0;
      endcase
    end
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_t         fn,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  parameter int NREGS      = 32,
  parameter int LD_AW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_dmem,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [RIDX_W-1:0] dbg_wr_reg,
  output logic [XLEN-1:0]   dbg_wr_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // ---------------- storage ----------------
  logic [INSN_W-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0]   dmem [DMEM_WORDS];

  // ---------------- stage registers ----------------
  logic [XLEN-1:0]   pc;
  logic [INSN_W-1:0] ifid_ir;
  logic [XLEN-1:0]   ifid_npc;
  logic              ifid_v;

  ctrl_t             idex_c;
  logic [XLEN-1:0]   idex_a, idex_b, idex_imm, idex_npc;

  logic              exmem_wr, exmem_ld, exmem_st, exmem_br, exmem_cond;
  logic [RIDX_W-1:0] exmem_dest;
  logic [XLEN-1:0]   exmem_alu, exmem_b;

  logic              memwb_wr, memwb_ld;
  logic [RIDX_W-1:0] memwb_dest;
  logic [XLEN-1:0]   memwb_alu, memwb_lmd;

  logic              taken;
  assign taken = exmem_br & exmem_cond;

  // ---------------- IF ----------------
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
    ifid_ir <= imem[pc[IAW+1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ifid_v   <= 1'b0;
      ifid_npc <= '0;
    end else begin
      pc       <= taken ? exmem_alu : pc + STEP;
      ifid_v   <= !taken;
      ifid_npc <= pc + STEP;
    end
  end

  // ---------------- ID ----------------
  ctrl_t             id_c;
  logic [XLEN-1:0]   id_imm, id_a, id_b;
  logic [RIDX_W-1:0] id_rs, id_rt;
  logic              wb_we;
  logic [XLEN-1:0]   wb_data;

  pipe5_decode #(.XLEN(XLEN)) u_dec (
    .ir    (ifid_ir),
    .valid (ifid_v),
    .ctrl  (id_c),
    .imm   (id_imm),
    .rs    (id_rs),
    .rt    (id_rt)
  );

  pipe5_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk (clk),
    .we  (wb_we),
    .wa  (memwb_dest),
    .wd  (wb_data),
    .ra1 (id_rs),
    .ra2 (id_rt),
    .rd1 (id_a),
    .rd2 (id_b)
  );

  always_ff @(posedge clk) begin
    if (rst || taken) idex_c <= '0;
    else              idex_c <= id_c;
    idex_a   <= id_a;
    idex_b   <= id_b;
    idex_imm <= id_imm;
    idex_npc <= ifid_npc;
  end

  // ---------------- EX ----------------
  logic [XLEN-1:0] ex_opa, ex_opb, ex_y;

  always_comb begin
    if (idex_c.branch) begin
      ex_opa = idex_npc;
      ex_opb = idex_imm << 2;
    end else begin
      ex_opa = idex_a;
      ex_opb = idex_c.use_imm ? idex_imm : idex_b;
    end
  end

  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .a  (ex_opa),
    .b  (ex_opb),
    .fn (idex_c.fn),
    .y  (ex_y)
  );

  always_ff @(posedge clk) begin
    if (rst || taken) begin
      exmem_wr <= 1'b0;
      exmem_ld <= 1'b0;
      exmem_st <= 1'b0;
      exmem_br <= 1'b0;
    end else begin
      exmem_wr <= idex_c.reg_wr;
      exmem_ld <= idex_c.mem_rd;
      exmem_st <= idex_c.mem_wr;
      exmem_br <= idex_c.branch;
    end
    exmem_cond <= (idex_a == '0);
    exmem_dest <= idex_c.dest;
    exmem_alu  <= ex_y;
    exmem_b    <= idex_b;
  end

  // ---------------- MEM ----------------
  logic [DAW-1:0] mem_idx;
  assign mem_idx = exmem_alu[DAW+1:2];

  always_ff @(posedge clk) begin
    if (exmem_st)                dmem[mem_idx] <= exmem_b;
    else if (ld_en && ld_dmem)   dmem[ld_addr[DAW-1:0]] <= ld_data;
    memwb_lmd <= dmem[mem_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_wr <= 1'b0;
      memwb_ld <= 1'b0;
    end else begin
      memwb_wr <= exmem_wr;
      memwb_ld <= exmem_ld;
    end
    memwb_dest <= exmem_dest;
    memwb_alu  <= exmem_alu;
  end

  // ---------------- WB ----------------
  assign wb_we   = memwb_wr;
  assign wb_data = memwb_ld ? memwb_lmd : memwb_alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_wr_en   <= 1'b0;
      dbg_wr_reg  <= '0;
      dbg_wr_data <= '0;
    end else begin
      dbg_wr_en   <= wb_we && (memwb_dest != '0);
      dbg_wr_reg  <= memwb_dest;
      dbg_wr_data <= wb_data;
    end
  end

  assign dbg_pc = pc;

  // ---------------- assertions ----------------
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !ifid_v && idex_c == '0 && !exmem_wr && !exmem_st
             && !exmem_br && !memwb_wr && !dbg_wr_en));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc == $past(pc) + STEP));

  p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc == $past(exmem_alu)));

  p_squash_r8: assert property (@(posedge clk) disable iff (rst)
    taken |=> (!ifid_v && idex_c == '0 && !exmem_wr && !exmem_st && !exmem_br));

  p_store_no_regwr_r6: assert property (@(posedge clk) disable iff (rst)
    exmem_st |-> !exmem_wr);

  p_no_r0_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> (dbg_wr_reg != '0));

endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_reg;
  logic [31:0] dbg_wr_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [4:0]  q_reg [$];
  logic [31:0] q_dat [$];
  string       q_tag [$];

  pipe5_core dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_reg(dbg_wr_reg), .dbg_wr_data(dbg_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(logic [4:0] r, logic [31:0] d, string tag);
    q_reg.push_back(r);
    q_dat.push_back(d);
    q_tag.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dbg_wr_en) begin
      checks++;
      if (q_reg.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected write actual=r%0d:%h expected=none",
                 dbg_wr_reg, dbg_wr_data);
      end else begin
        logic [4:0]  er;
        logic [31:0] ed;
        string       et;
        er = q_reg.pop_front();
        ed = q_dat.pop_front();
        et = q_tag.pop_front();
        if (dbg_wr_reg != er || dbg_wr_data != ed) begin
          errors++;
          $display("FAIL %s actual=r%0d:%h expected=r%0d:%h",
                   et, dbg_wr_reg, dbg_wr_data, er, ed);
        end
      end
    end
  end

  task automatic put(bit sel, int addr, logic [31:0] data);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_dmem = sel;
    ld_addr = 8'(addr);
    ld_data = data;
  endtask

  task automatic load_program();
    logic [31:0] p [32];
    for (int i = 0; i < 32; i++) p[i] = 32'h0;
    p[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
    p[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
    p[2]  = 32'hFC01FFFF;                         // unsupported opcode
    p[4]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    p[5]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
    p[6]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
    p[7]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
    p[8]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
    p[9]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
    p[10] = enc_i(6'h2B, 5'd0, 5'd1, 16'd8);       // SW r1 -> byte 8
    p[11] = enc_i(6'h08, 5'd0, 5'd0, 16'd7);       // write to r0
    p[12] = enc_i(6'h23, 5'd1, 5'd9, 16'd3);       // LW r9 <- 5+3
    p[13] = enc_i(6'h04, 5'd0, 5'd0, 16'd6);       // taken -> word 20
    p[14] = enc_i(6'h08, 5'd0, 5'd10, 16'd1);
    p[15] = enc_i(6'h08, 5'd0, 5'd11, 16'd2);
    p[16] = enc_i(6'h08, 5'd0, 5'd12, 16'd3);
    for (int i = 17; i < 20; i++) p[i] = enc_i(6'h08, 5'd0, 5'd13, 16'd4);
    p[20] = enc_i(6'h04, 5'd1, 5'd0, 16'd5);       // not taken
    p[21] = enc_i(6'h08, 5'd0, 5'd14, 16'h7FFF);
    p[22] = enc_i(6'h08, 5'd1, 5'd15, 16'hFFFF);
    p[23] = enc_i(6'h23, 5'd0, 5'd16, 16'd0);
    p[24] = enc_i(6'h08, 5'd0, 5'd17, 16'd0);
    p[27] = enc_r(5'd0, 5'd1, 5'd18, 6'h20);
    p[28] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);    // branch to self
    for (int i = 29; i < 32; i++) p[i] = enc_i(6'h08, 5'd0, 5'd19, 16'd9);
    for (int i = 0; i < 32; i++) put(1'b0, i, p[i]);
  endtask

  task automatic run_program(logic [31:0] d0);
    rst = 1'b1;
    load_program();
    put(1'b1, 0, d0);
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);
    check(dbg_pc == 32'h0, "R1 pc in reset", dbg_pc, 32'h0);
    check(dbg_wr_en == 1'b0, "R1 strobe in reset", 32'(dbg_wr_en), 32'h0);

    expect_wr(5'd1,  32'd5,        "R5 addi r1");
    expect_wr(5'd2,  32'hFFFFFFFD, "R3 sign-extended imm r2");
    expect_wr(5'd3,  32'd2,        "R4 R9 R11 add at distance three");
    expect_wr(5'd4,  32'd8,        "R4 sub");
    expect_wr(5'd5,  32'd5,        "R4 and");
    expect_wr(5'd6,  32'hFFFFFFFD, "R4 or");
    expect_wr(5'd7,  32'd1,        "R4 slt signed true");
    expect_wr(5'd8,  32'd0,        "R4 slt signed false");
    expect_wr(5'd9,  32'd5,        "R6 R10 store then load");
    expect_wr(5'd14, 32'h00007FFF, "R7 R8 squash and fall-through");
    expect_wr(5'd15, 32'd4,        "R5 addi negative");
    expect_wr(5'd16, d0,           "R12 preloaded data word");
    expect_wr(5'd17, 32'd0,        "R13 zero-valued write");
    expect_wr(5'd18, 32'd5,        "R10 r0 reads zero");

    rst = 1'b0;
    @(negedge clk);
    check(dbg_pc == 32'd4, "R2 pc after one clock", dbg_pc, 32'd4);
    @(negedge clk);
    check(dbg_pc == 32'd8, "R2 pc after two clocks", dbg_pc, 32'd8);

    for (int i = 0; i < 200 && q_reg.size() != 0; i++) @(negedge clk);
    repeat (24) @(negedge clk);
    check(q_reg.size() == 0, "R13 all writes retired", 32'(q_reg.size()), 32'h0);
    check(dbg_pc >= 32'd112 && dbg_pc <= 32'd124, "R7 R8 loop window",
          dbg_pc, 32'd112);
  endtask

  initial begin
    run_program(32'hCAFEF00D);
    run_program(32'h12345678);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule